// File: doc/BRIEF.md
# Configuration Channel Transaction Engine

This block runs single read or write transactions against a small indexed bank of oscillator-frequency registers. Software first loads a 32-bit outgoing data register. It then stores a control word that carries a device index, a function code, a direction flag and a launch bit. When the launch bit is set, the engine stays busy for a fixed two cycles and then finishes the transaction. A valid write copies the outgoing data into the chosen oscillator entry. A valid read copies the chosen entry into a return register. A status word reports the outcome as a done bit plus an error bit.

A transaction is valid only when the function code selects the oscillator function (code 1) and the device index falls inside the bank. Anything else completes with both done and error set and moves no data. The bank size and the reset value of each entry are parameters. The whole bank is also driven onto a flat output bus so that it can be observed.

Top module: `cfg_channel_engine`

## Requirements
- R1: A stored control word keeps device index [11:0], function code [25:20] and direction flag [30] (1 = write). Reserved bits [19:12] and [29:26] and the launch bit [31] always read back as zero.
- R2: After reset the control word reads 0x0010_0000 and the status word reads 0. The outgoing and return data registers read 0, and oscillator entry i holds slice i of the OSC_RESET parameter.
- R3: Every accepted control write clears the whole status word on the edge that accepts it.
- R4: The status word holds done in bit 0 and error in bit 1, with all other bits zero. A launched transaction raises busy for exactly two cycles after the accepting edge. Done appears, and busy falls, on the second edge after that.
- R5: A transaction is valid only if the function code equals 1 and the device index is below NUM_OSC. An invalid transaction sets error together with done. A valid one sets done with error clear.
- R6: A valid write copies the outgoing data register into the selected oscillator entry and leaves the other entries unchanged.
- R7: A valid read loads the selected entry into the return register. An invalid read or write leaves the return register and every oscillator entry unchanged.
- R8: While busy, control writes and outgoing-data writes are ignored. The stored control word and the outgoing data are unchanged, and no further transaction starts.
- R9: Oscillator entry i appears on oscBus bits [32*i+31:32*i].
- R10: A control write with the launch bit clear stores the word and clears status, but starts nothing. Busy stays low and status stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 32 | Control word to store |
| dataOutWrEn | input | 1 | Outgoing data write strobe |
| dataOutWrData | input | 32 | Outgoing data value |
| ctrlRead | output | 32 | Stored control word |
| statusRead | output | 32 | Status word (bit 0 done, bit 1 error) |
| dataOutRead | output | 32 | Outgoing data register |
| dataRtnRead | output | 32 | Return data register |
| busy | output | 1 | Transaction in flight |
| oscBus | output | 32*NUM_OSC | All oscillator entries, entry 0 in the low bits |

## Verification
The assertions assume that the write strobes are free of X after reset and change only between clock edges. They also assume NUM_OSC is between 1 and 4096, so every index fits the 12-bit field. The bench drives all inputs on the falling edge and returns the strobes to zero after one cycle. It sweeps function codes and device indices across and beyond the bank bound, both on its own and with writes pushed into the busy window, so every case stays inside these assumptions.

// File: rtl/cfgchan_pkg.sv
package cfgchan_pkg;

  localparam int WORD_W = 32;
  localparam int DEV_W = 12;
  localparam int FUNC_W = 6;
  localparam int DEV_LSB = 0;
  localparam int FUNC_LSB = 20;
  localparam int DIR_BIT = 30;
  localparam int GO_BIT = 31;

  // bits that survive storage: device, function, direction
  localparam logic [WORD_W-1:0] KEEP_MASK = 32'h43F0_0FFF;
  localparam logic [WORD_W-1:0] CTRL_RESET = 32'h0010_0000;
  localparam logic [FUNC_W-1:0] FUNC_OSC = 6'd1;

  typedef struct packed {
    logic capture;   // accept control write
    logic launch;    // accepted write carries the launch bit
    logic loadData;  // accept outgoing data write
    logic finish;    // complete the pending transaction
  } chanStrobes_t;

endpackage

// File: rtl/cfgchan_ctrl.sv
module cfgchan_ctrl
  import cfgchan_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         ctrlWrEn,
  input  logic         startReq,
  input  logic         dataOutWrEn,
  output chanStrobes_t strb,
  output logic         busy
);

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FINAL} chanState_t;

  chanState_t state, stateNext;

  always_comb begin
    strb = '0;
    strb.capture  = ctrlWrEn && (state == ST_IDLE);
    strb.launch   = strb.capture && startReq;
    strb.loadData = dataOutWrEn && (state == ST_IDLE);
    strb.finish   = (state == ST_FINAL);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (strb.launch) stateNext = ST_RUN;
      ST_RUN:   stateNext = ST_FINAL;
      ST_FINAL: stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

  // R4: busy lasts exactly two cycles
  assert_busy_min_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |=> busy);
  assert_busy_max_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |=> !busy);
  // R10: a control write without the launch bit leaves the engine idle
  assert_no_launch_R10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrEn && !startReq && !busy) |=> !busy);

endmodule

// File: rtl/cfgchan_dp.sv
module cfgchan_dp
  import cfgchan_pkg::*;
#(
  parameter int NUM_OSC = 3,
  parameter logic [NUM_OSC*32-1:0] OSC_RESET = '0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  chanStrobes_t            strb,
  input  logic                    busyIn,
  input  logic                    rawCtrlWr,
  input  logic                    rawDataWr,
  input  logic [WORD_W-1:0]       ctrlWrData,
  input  logic [WORD_W-1:0]       dataOutWrData,
  output logic [WORD_W-1:0]       ctrlRead,
  output logic [WORD_W-1:0]       statusRead,
  output logic [WORD_W-1:0]       dataOutRead,
  output logic [WORD_W-1:0]       dataRtnRead,
  output logic [NUM_OSC*32-1:0]   oscBus
);

  localparam logic [DEV_W:0] OSC_LIMIT = (DEV_W+1)'(NUM_OSC);

  logic [WORD_W-1:0] ctrlReg, statusReg, dataOutReg, dataRtnReg;
  logic [WORD_W-1:0] oscReg [NUM_OSC];
  logic [DEV_W-1:0]  devIdx;
  logic [FUNC_W-1:0] funcCode;
  logic              isWrite, cmdValid;
  logic [WORD_W-1:0] rdMux;

  assign devIdx   = ctrlReg[DEV_LSB +: DEV_W];
  assign funcCode = ctrlReg[FUNC_LSB +: FUNC_W];
  assign isWrite  = ctrlReg[DIR_BIT];
  assign cmdValid = (funcCode == FUNC_OSC) && ({1'b0, devIdx} < OSC_LIMIT);

  always_comb begin
    rdMux = '0;
    for (int i = 0; i < NUM_OSC; i++) begin
      if (devIdx == DEV_W'(i)) rdMux = oscReg[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg    <= CTRL_RESET;
      statusReg  <= '0;
      dataOutReg <= '0;
      dataRtnReg <= '0;
    end else begin
      if (strb.capture) begin
        ctrlReg   <= ctrlWrData & KEEP_MASK;
        statusReg <= '0;
      end else if (strb.finish) begin
        statusReg <= {30'd0, !cmdValid, 1'b1};
      end
      if (strb.loadData) dataOutReg <= dataOutWrData;
      if (strb.finish && cmdValid && !isWrite) dataRtnReg <= rdMux;
    end
  end

  for (genvar g = 0; g < NUM_OSC; g++) begin : gen_osc
    always_ff @(posedge clk) begin
      if (!rstN)
        oscReg[g] <= OSC_RESET[g*32 +: 32];
      else if (strb.finish && cmdValid && isWrite && devIdx == DEV_W'(g))
        oscReg[g] <= dataOutReg;
    end
    assign oscBus[g*32 +: 32] = oscReg[g];
  end

  assign ctrlRead    = ctrlReg;
  assign statusRead  = statusReg;
  assign dataOutRead = dataOutReg;
  assign dataRtnRead = dataRtnReg;

  // R4: done rises only as a busy window closes
  assert_done_after_busy_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statusReg[0]) |-> $past(busyIn));
  // R7: a failed transaction keeps the return register
  assert_rtn_kept_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.finish && !cmdValid) |=> $stable(dataRtnReg));
  // R8: writes during busy do not disturb stored registers
  assert_ctrl_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rawCtrlWr && busyIn) |=> $stable(ctrlReg));
  assert_data_ignored_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rawDataWr && busyIn) |=> $stable(dataOutReg));
  // R6: the bank changes only on a finishing write
  assert_bank_quiet_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.finish |=> $stable(oscBus));

endmodule

// File: rtl/cfg_channel_engine.sv
module cfg_channel_engine
  import cfgchan_pkg::*;
#(
  parameter int NUM_OSC = 3,
  parameter logic [NUM_OSC*32-1:0] OSC_RESET =
    {32'h0165_A0BC, 32'h02DC_6C00, 32'h017D_7840}
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ctrlWrEn,
  input  logic [31:0]           ctrlWrData,
  input  logic                  dataOutWrEn,
  input  logic [31:0]           dataOutWrData,
  output logic [31:0]           ctrlRead,
  output logic [31:0]           statusRead,
  output logic [31:0]           dataOutRead,
  output logic [31:0]           dataRtnRead,
  output logic                  busy,
  output logic [NUM_OSC*32-1:0] oscBus
);

  chanStrobes_t strb;

  cfgchan_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .ctrlWrEn   (ctrlWrEn),
    .startReq   (ctrlWrData[GO_BIT]),
    .dataOutWrEn(dataOutWrEn),
    .strb       (strb),
    .busy       (busy)
  );

  cfgchan_dp #(.NUM_OSC(NUM_OSC), .OSC_RESET(OSC_RESET)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .busyIn       (busy),
    .rawCtrlWr    (ctrlWrEn),
    .rawDataWr    (dataOutWrEn),
    .ctrlWrData   (ctrlWrData),
    .dataOutWrData(dataOutWrData),
    .ctrlRead     (ctrlRead),
    .statusRead   (statusRead),
    .dataOutRead  (dataOutRead),
    .dataRtnRead  (dataRtnRead),
    .oscBus       (oscBus)
  );

endmodule

// File: tb/tb_cfg_channel_engine.sv
`timescale 1ns/1ps
module tb_cfg_channel_engine;

  localparam int N = 3;
  localparam logic [N*32-1:0] RST_VALS = {32'h0165_A0BC, 32'h02DC_6C00, 32'h017D_7840};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 1'b0, dataOutWrEn = 1'b0;
  logic [31:0] ctrlWrData = '0, dataOutWrData = '0;
  logic [31:0] ctrlRead, statusRead, dataOutRead, dataRtnRead;
  logic busy;
  logic [N*32-1:0] oscBus;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] model [N];
  logic [31:0] expRtn;

  always #2.5 clk = ~clk;

  cfg_channel_engine #(.NUM_OSC(N), .OSC_RESET(RST_VALS)) dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .dataOutWrEn(dataOutWrEn), .dataOutWrData(dataOutWrData),
    .ctrlRead(ctrlRead), .statusRead(statusRead), .dataOutRead(dataOutRead),
    .dataRtnRead(dataRtnRead), .busy(busy), .oscBus(oscBus));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkBank(input string tag);
    for (int i = 0; i < N; i++) check(tag, oscBus[i*32 +: 32], model[i]);
  endtask

  // one transaction; hostile=1 pushes writes into the busy window
  task automatic runTxn(input logic wr, input logic [5:0] fn, input logic [11:0] dev,
                        input logic [31:0] payload, input bit hostile);
    logic ok;
    logic [31:0] expCtrl;
    ok = (fn == 6'd1) && (dev < 12'(N));
    expCtrl = {1'b0, wr, 4'h0, fn, 8'h00, dev};
    @(negedge clk);
    dataOutWrEn = 1'b1; dataOutWrData = payload;
    @(negedge clk);
    dataOutWrEn = 1'b0;
    check("R8 data-out load", dataOutRead, payload);
    ctrlWrEn = 1'b1;
    ctrlWrData = {1'b1, wr, 4'hF, fn, 8'hA5, dev};
    @(negedge clk);
    ctrlWrEn = 1'b0;
    check("R4 busy cycle1", {31'd0, busy}, 32'd1);
    check("R3 status cleared", statusRead, 32'd0);
    check("R1 stored control", ctrlRead, expCtrl);
    if (hostile) begin
      ctrlWrEn = 1'b1; ctrlWrData = 32'hC000_0000 | 32'h0010_0000;
      dataOutWrEn = 1'b1; dataOutWrData = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    ctrlWrEn = 1'b0; dataOutWrEn = 1'b0;
    check("R4 busy cycle2", {31'd0, busy}, 32'd1);
    check("R4 status still clear", statusRead, 32'd0);
    @(negedge clk);
    if (ok && wr) model[dev[1:0]] = payload;
    if (ok && !wr) expRtn = model[dev[1:0]];
    check("R4 busy low", {31'd0, busy}, 32'd0);
    check("R5 status", statusRead, {30'd0, !ok, 1'b1});
    check("R7 return", dataRtnRead, expRtn);
    checkBank("R6 R9 bank");
    if (hostile) begin
      check("R8 control kept", ctrlRead, expCtrl);
      check("R8 data-out kept", dataOutRead, payload);
      @(negedge clk);
      check("R8 no relaunch", {31'd0, busy}, 32'd0);
      checkBank("R8 bank kept");
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [5:0] fns [4];
    logic [11:0] devs [6];
    int n;
    fns = '{6'd0, 6'd1, 6'd2, 6'd63};
    devs = '{12'd0, 12'd1, 12'd2, 12'd3, 12'd4, 12'hFFF};
    for (int i = 0; i < N; i++) model[i] = RST_VALS[i*32 +: 32];
    expRtn = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 control reset", ctrlRead, 32'h0010_0000);
    check("R2 status reset", statusRead, 32'd0);
    check("R2 data-out reset", dataOutRead, 32'd0);
    check("R2 return reset", dataRtnRead, 32'd0);
    check("R2 busy reset", {31'd0, busy}, 32'd0);
    checkBank("R2 R9 bank reset");

    n = 0;
    for (int pass = 0; pass < 2; pass++)
      for (int w = 1; w >= 0; w--)
        for (int f = 0; f < 4; f++)
          for (int d = 0; d < 6; d++) begin
            runTxn(w[0], fns[f], devs[d], 32'hC0DE_0000 + 32'(n * 37), 1'b0);
            n++;
          end

    // R8: writes during busy are dropped
    runTxn(1'b1, 6'd1, 12'd2, 32'h1234_5678, 1'b1);
    runTxn(1'b0, 6'd1, 12'd1, 32'h0BAD_F00D, 1'b1);
    runTxn(1'b0, 6'd5, 12'd0, 32'h0000_0001, 1'b1);

    // R10: no launch bit
    @(negedge clk);
    ctrlWrEn = 1'b1; ctrlWrData = 32'h7FFF_FFFF;
    @(negedge clk);
    ctrlWrEn = 1'b0;
    check("R10 stored", ctrlRead, 32'h43F0_0FFF);
    check("R10 status cleared", statusRead, 32'd0);
    check("R10 idle", {31'd0, busy}, 32'd0);
    repeat (2) @(negedge clk);
    check("R10 still idle", {31'd0, busy}, 32'd0);
    check("R10 status stays 0", statusRead, 32'd0);
    checkBank("R10 bank kept");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule